// File: doc/BRIEF.md
# Isochronous-Aware Data Phase Sequencer

This block runs the data phase of a transaction on a graphics port. A requester presents a 3-bit status code with a valid strobe and a payload length in 32-byte units. The sequencer decodes the code. It then raises a data-valid strobe on each clock that carries one unit, and it pulses done on the clock that carries the last unit. Asynchronous transfers honour the initiator and target ready strobes and the buffer-full throttles, but only where a new four-clock block of the data phase begins. Isochronous transfers may start one clock late at most. Once they start they run on back-to-back clocks, and neither the ready strobes nor the throttles can stall them.

A calibration request is granted as a one-clock pulse. The grant is given only while the sequencer is idle and no isochronous status is being presented, so calibration never sits in front of an isochronous transfer. Reserved codes, a bad length and an isochronous start that misses its one-clock allowance all raise the protocol error output.

Top module: `iso_phase_seq`

## Requirements
- R1: While idle, a valid status starts a data phase on the next clock for code 000 (asynchronous read), 010 (asynchronous write), 100 (isochronous read) or 101 (isochronous write). Codes 110 (calibration) and 111 (grant) start none and raise no error.
- R2: While idle, a valid status of 001 or 011 (reserved) raises proto_err_o on the same clock and starts no data phase.
- R3: While idle, a data code with a length of 0 or above 8 raises proto_err_o on the same clock and starts no data phase.
- R4: A data phase of length L gives exactly L clocks with data_vld_o high. done_o is high together with data_vld_o on the clock of the L-th unit, and never at any other time.
- R5: An isochronous phase gives its first unit on the first clock of the phase if its ready strobe is low (irdy_n_i for a write, trdy_n_i for a read). Otherwise it gives that unit on the second clock.
- R6: If that ready strobe is still high on the second clock, proto_err_o is high on that clock, no unit is given, and the sequencer returns to idle.
- R7: After its first unit, an isochronous phase gives one unit on every clock whatever irdy_n_i, trdy_n_i, rbf_i and wbf_i are.
- R8: In an asynchronous phase, a unit whose index (counted from 0) is a multiple of 4 moves only on a clock where irdy_n_i and trdy_n_i are low and the buffer-full throttle is low (rbf_i for a read, wbf_i for a write). Otherwise that clock is a wait state.
- R9: In an asynchronous phase, units whose index is not a multiple of 4 move on consecutive clocks whatever the strobes and throttles are.
- R10: cal_gnt_o is high exactly on clocks where cal_req_i is high, the sequencer is idle, and there is no valid status with an isochronous code (100 or 101).
- R11: A valid status presented during a data phase is ignored. It raises no error and does not change the phase in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| status_vld_i | input | 1 | Status code valid |
| status_i | input | 3 | Status code |
| len_i | input | 4 | Payload length in 32-byte units |
| irdy_n_i | input | 1 | Initiator ready, active low |
| trdy_n_i | input | 1 | Target ready, active low |
| rbf_i | input | 1 | Read buffer full throttle |
| wbf_i | input | 1 | Write buffer full throttle |
| cal_req_i | input | 1 | Calibration request |
| data_vld_o | output | 1 | One payload unit moves this clock |
| done_o | output | 1 | Final unit of the phase moves this clock |
| cal_gnt_o | output | 1 | Calibration granted this clock |
| proto_err_o | output | 1 | Protocol error this clock |

## Verification
The hardest situations to reach from the ports are an isochronous start whose ready strobe stays high for two clocks in a row, and an asynchronous phase longer than four units that is throttled just at its second block boundary. Both need a particular strobe pattern at one exact clock of a phase. Directed sequences place those patterns on purpose. The random phase holds ready strobes high about a quarter of the time and throttles often, so late starts, aborts and boundary wait states recur across all lengths. A cycle model in the bench tracks phase, unit index and late-start state, and predicts all four outputs on every clock.

// File: rtl/iso_seq_pkg.sv
package iso_seq_pkg;

  typedef enum logic [2:0] {
    KIND_NONE, KIND_ARD, KIND_AWR, KIND_IRD, KIND_IWR, KIND_CAL, KIND_GNT, KIND_RSV
  } kind_e;

  typedef enum logic [2:0] {
    PH_IDLE, PH_ASYNC, PH_ISO_FIRST, PH_ISO_LATE, PH_ISO_RUN
  } phase_e;

  function automatic kind_e decode_status(input logic [2:0] code);
    kind_e k;
    case (code)
      3'b000:  k = KIND_ARD;
      3'b010:  k = KIND_AWR;
      3'b100:  k = KIND_IRD;
      3'b101:  k = KIND_IWR;
      3'b110:  k = KIND_CAL;
      3'b111:  k = KIND_GNT;
      default: k = KIND_RSV;
    endcase
    return k;
  endfunction

  function automatic logic kind_is_iso(input kind_e k);
    return (k == KIND_IRD) || (k == KIND_IWR);
  endfunction

  function automatic logic kind_is_data(input kind_e k);
    return (k == KIND_ARD) || (k == KIND_AWR) || kind_is_iso(k);
  endfunction

  function automatic logic kind_is_write(input kind_e k);
    return (k == KIND_AWR) || (k == KIND_IWR);
  endfunction

  function automatic logic length_bad(input int unsigned len, input int unsigned max_units);
    return (len == 0) || (len > max_units);
  endfunction

  function automatic logic on_gate(input int unsigned idx, input int unsigned gate);
    return (idx % gate) == 0;
  endfunction

endpackage

// File: rtl/iso_status_decode.sv
module iso_status_decode
  import iso_seq_pkg::*;
#(
  parameter int unsigned MAX_UNITS = 8,
  parameter int unsigned LEN_W     = 4
) (
  input  logic [2:0]       status_i,
  input  logic [LEN_W-1:0] len_i,
  output kind_e            kind_o,
  output logic             is_iso_o,
  output logic             is_data_o,
  output logic             is_write_o,
  output logic             is_rsv_o,
  output logic             len_bad_o
);

  always_comb begin
    kind_o     = decode_status(status_i);
    is_iso_o   = kind_is_iso(kind_o);
    is_data_o  = kind_is_data(kind_o);
    is_write_o = kind_is_write(kind_o);
    is_rsv_o   = (kind_o == KIND_RSV);
    len_bad_o  = length_bad(32'(len_i), MAX_UNITS);
  end

endmodule

// File: rtl/iso_beat_counter.sv
module iso_beat_counter
  import iso_seq_pkg::*;
#(
  parameter int unsigned LEN_W     = 4,
  parameter int unsigned GATE_CLKS = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_i,
  input  logic [LEN_W-1:0] len_i,
  input  logic             step_i,
  output logic [LEN_W-1:0] idx_o,
  output logic             last_o,
  output logic             at_gate_o
);

  logic [LEN_W-1:0] len_q;
  logic [LEN_W-1:0] idx_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      len_q <= '0;
      idx_q <= '0;
    end else if (load_i) begin
      len_q <= len_i;
      idx_q <= '0;
    end else if (step_i) begin
      idx_q <= idx_q + 1'b1;
    end
  end

  always_comb begin
    idx_o     = idx_q;
    last_o    = (idx_q == len_q - 1'b1);
    at_gate_o = on_gate(32'(idx_q), GATE_CLKS);
  end

endmodule

// File: rtl/iso_phase_fsm.sv
module iso_phase_fsm
  import iso_seq_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   start_i,
  input  logic   is_iso_i,
  input  logic   is_data_i,
  input  logic   is_write_i,
  input  logic   is_rsv_i,
  input  logic   len_bad_i,
  input  logic   irdy_n_i,
  input  logic   trdy_n_i,
  input  logic   rbf_i,
  input  logic   wbf_i,
  input  logic   cal_req_i,
  input  logic   last_i,
  input  logic   at_gate_i,
  output logic   load_o,
  output logic   beat_o,
  output logic   done_o,
  output logic   err_o,
  output logic   cal_gnt_o,
  output logic   busy_o,
  output logic   iso_mode_o,
  output logic   iso_late_o,
  output logic   ready_sel_o
);

  phase_e phase_q, phase_d;
  logic   wr_q, iso_q;
  logic   full_sel, async_ok, accept;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= PH_IDLE;
      wr_q    <= 1'b0;
      iso_q   <= 1'b0;
    end else begin
      phase_q <= phase_d;
      if (load_o) begin
        wr_q  <= is_write_i;
        iso_q <= is_iso_i;
      end
    end
  end

  always_comb begin
    ready_sel_o = wr_q ? !irdy_n_i : !trdy_n_i;
    full_sel    = wr_q ? wbf_i : rbf_i;
    async_ok    = !irdy_n_i && !trdy_n_i && !full_sel;
    accept      = start_i && is_data_i && !len_bad_i;
    phase_d     = phase_q;
    load_o      = 1'b0;
    beat_o      = 1'b0;
    err_o       = 1'b0;
    cal_gnt_o   = 1'b0;
    case (phase_q)
      PH_IDLE: begin
        cal_gnt_o = cal_req_i && !(start_i && is_iso_i);
        err_o     = start_i && (is_rsv_i || (is_data_i && len_bad_i));
        if (accept) begin
          load_o  = 1'b1;
          phase_d = is_iso_i ? PH_ISO_FIRST : PH_ASYNC;
        end
      end
      PH_ASYNC: begin
        beat_o = at_gate_i ? async_ok : 1'b1;
        if (beat_o && last_i) phase_d = PH_IDLE;
      end
      PH_ISO_FIRST: begin
        beat_o = ready_sel_o;
        if (beat_o) phase_d = last_i ? PH_IDLE : PH_ISO_RUN;
        else        phase_d = PH_ISO_LATE;
      end
      PH_ISO_LATE: begin
        beat_o = ready_sel_o;
        if (beat_o) phase_d = last_i ? PH_IDLE : PH_ISO_RUN;
        else begin
          err_o   = 1'b1;
          phase_d = PH_IDLE;
        end
      end
      PH_ISO_RUN: begin
        beat_o = 1'b1;
        if (last_i) phase_d = PH_IDLE;
      end
      default: phase_d = PH_IDLE;
    endcase
    done_o     = beat_o && last_i;
    busy_o     = (phase_q != PH_IDLE);
    iso_mode_o = busy_o && iso_q;
    iso_late_o = (phase_q == PH_ISO_LATE);
  end

endmodule

// File: rtl/iso_phase_seq.sv
module iso_phase_seq
  import iso_seq_pkg::*;
#(
  parameter int unsigned MAX_UNITS = 8,
  parameter int unsigned GATE_CLKS = 4,
  parameter int unsigned LEN_W     = $clog2(MAX_UNITS + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             status_vld_i,
  input  logic [2:0]       status_i,
  input  logic [LEN_W-1:0] len_i,
  input  logic             irdy_n_i,
  input  logic             trdy_n_i,
  input  logic             rbf_i,
  input  logic             wbf_i,
  input  logic             cal_req_i,
  output logic             data_vld_o,
  output logic             done_o,
  output logic             cal_gnt_o,
  output logic             proto_err_o
);

  kind_e            kind;
  logic             is_iso, is_data, is_write, is_rsv, len_bad;
  logic             load, beat, done, err, cal_gnt;
  logic             busy, iso_mode, iso_late, ready_sel;
  logic             last, at_gate;
  logic [LEN_W-1:0] beat_idx;

  iso_status_decode #(.MAX_UNITS(MAX_UNITS), .LEN_W(LEN_W)) u_dec (
    .status_i  (status_i),
    .len_i     (len_i),
    .kind_o    (kind),
    .is_iso_o  (is_iso),
    .is_data_o (is_data),
    .is_write_o(is_write),
    .is_rsv_o  (is_rsv),
    .len_bad_o (len_bad)
  );

  iso_beat_counter #(.LEN_W(LEN_W), .GATE_CLKS(GATE_CLKS)) u_cnt (
    .clk      (clk),
    .rst_n    (rst_n),
    .load_i   (load),
    .len_i    (len_i),
    .step_i   (beat),
    .idx_o    (beat_idx),
    .last_o   (last),
    .at_gate_o(at_gate)
  );

  iso_phase_fsm u_fsm (
    .clk        (clk),
    .rst_n      (rst_n),
    .start_i    (status_vld_i),
    .is_iso_i   (is_iso),
    .is_data_i  (is_data),
    .is_write_i (is_write),
    .is_rsv_i   (is_rsv),
    .len_bad_i  (len_bad),
    .irdy_n_i   (irdy_n_i),
    .trdy_n_i   (trdy_n_i),
    .rbf_i      (rbf_i),
    .wbf_i      (wbf_i),
    .cal_req_i  (cal_req_i),
    .last_i     (last),
    .at_gate_i  (at_gate),
    .load_o     (load),
    .beat_o     (beat),
    .done_o     (done),
    .err_o      (err),
    .cal_gnt_o  (cal_gnt),
    .busy_o     (busy),
    .iso_mode_o (iso_mode),
    .iso_late_o (iso_late),
    .ready_sel_o(ready_sel)
  );

  assign data_vld_o  = beat;
  assign done_o      = done;
  assign cal_gnt_o   = cal_gnt;
  assign proto_err_o = err;

endmodule

// File: rtl/iso_phase_seq_chk.sv
module iso_phase_seq_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       status_vld_i,
  input logic [2:0] status_i,
  input logic       busy,
  input logic       iso_mode,
  input logic       iso_late,
  input logic       ready_sel,
  input logic       data_vld_o,
  input logic       done_o,
  input logic       cal_gnt_o,
  input logic       proto_err_o
);

  assert_rsv_err_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && status_vld_i && (status_i == 3'b001 || status_i == 3'b011)) |-> proto_err_o);

  assert_rsv_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && status_vld_i && (status_i == 3'b001 || status_i == 3'b011)) |=> !busy);

  assert_done_with_beat_R4: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> data_vld_o);

  assert_late_abort_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (iso_late && !ready_sel) |-> (proto_err_o && !data_vld_o));

  assert_late_idle_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (iso_late && !ready_sel) |=> !busy);

  assert_iso_no_gap_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (iso_mode && data_vld_o && !done_o) |=> data_vld_o);

  assert_cal_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
    cal_gnt_o |-> (!busy && !(status_vld_i && status_i[2:1] == 2'b10)));

  assert_busy_no_err_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !iso_late) |-> !proto_err_o);

endmodule

bind iso_phase_seq iso_phase_seq_chk u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .status_vld_i(status_vld_i),
  .status_i    (status_i),
  .busy        (busy),
  .iso_mode    (iso_mode),
  .iso_late    (iso_late),
  .ready_sel   (ready_sel),
  .data_vld_o  (data_vld_o),
  .done_o      (done_o),
  .cal_gnt_o   (cal_gnt_o),
  .proto_err_o (proto_err_o)
);

// File: tb/test_iso_phase_seq.sv
module test_iso_phase_seq;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       svld = 1'b0;
  logic [2:0] code = 3'b0;
  logic [3:0] len = 4'd0;
  logic       irdy_n = 1'b1, trdy_n = 1'b1, rbf = 1'b0, wbf = 1'b0, cal = 1'b0;
  logic       data_vld, done, cal_gnt, perr;

  int tests = 0;
  int fails = 0;

  // model state
  bit m_busy = 0, m_iso = 0, m_wr = 0, m_late = 0;
  int m_len = 0, m_beats = 0;

  always #10 clk = ~clk;

  iso_phase_seq i_iso_phase_seq (
    .clk(clk), .rst_n(rst_n), .status_vld_i(svld), .status_i(code), .len_i(len),
    .irdy_n_i(irdy_n), .trdy_n_i(trdy_n), .rbf_i(rbf), .wbf_i(wbf), .cal_req_i(cal),
    .data_vld_o(data_vld), .done_o(done), .cal_gnt_o(cal_gnt), .proto_err_o(perr)
  );

  task automatic check(input logic act, input logic exp, input string req, input string what);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%0b expected=%0b t=%0t", req, what, act, exp, $time);
    end
  endtask

  function automatic bit is_rsv(input logic [2:0] c);
    return (c == 3'b001) || (c == 3'b011);
  endfunction

  function automatic bit is_data_code(input logic [2:0] c);
    return (c == 3'b000) || (c == 3'b010) || (c == 3'b100) || (c == 3'b101);
  endfunction

  // predict outputs of this clock from model state and inputs, then advance the model
  task automatic model_step();
    bit e_vld = 0, e_done = 0, e_err = 0, e_cal = 0, rdy, full;
    string tv = "R1", te = "R2";
    if (!m_busy) begin
      e_cal = cal && !(svld && code[2:1] == 2'b10);
      if (svld && is_rsv(code)) begin e_err = 1; te = "R2"; end
      else if (svld && is_data_code(code) && (len < 1 || len > 8)) begin e_err = 1; te = "R3"; end
    end else if (!m_iso) begin
      full = m_wr ? wbf : rbf;
      if (m_beats % 4 == 0) begin e_vld = !irdy_n && !trdy_n && !full; tv = "R8"; end
      else begin e_vld = 1; tv = "R9"; end
      te = "R11";
    end else begin
      te = "R11";
      if (m_beats > 0) begin e_vld = 1; tv = "R7"; end
      else begin
        rdy = m_wr ? !irdy_n : !trdy_n;
        tv = "R5";
        if (rdy) e_vld = 1;
        else if (m_late) begin e_err = 1; te = "R6"; end
      end
    end
    if (e_vld) e_done = (m_beats == m_len - 1);
    check(data_vld, e_vld, tv, "data_vld");
    check(done, e_done, "R4", "done");
    check(perr, e_err, te, "proto_err");
    check(cal_gnt, e_cal, "R10", "cal_gnt");
    // advance
    if (!m_busy) begin
      if (svld && is_data_code(code) && len >= 1 && len <= 8) begin
        m_busy = 1; m_iso = code[2]; m_wr = (code == 3'b010) || (code == 3'b101);
        m_len = int'(len); m_beats = 0; m_late = 0;
      end
    end else begin
      if (e_vld) begin
        m_beats++;
        if (e_done) m_busy = 0;
      end else if (m_iso && m_beats == 0) begin
        if (e_err) m_busy = 0; else m_late = 1;
      end
    end
  endtask

  task automatic cyc(input bit v, input logic [2:0] c, input logic [3:0] l,
                     input bit i_n, input bit t_n, input bit rb, input bit wb, input bit cr);
    @(posedge clk); #1;
    svld = v; code = c; len = l; irdy_n = i_n; trdy_n = t_n; rbf = rb; wbf = wb; cal = cr;
    @(negedge clk);
    model_step();
  endtask

  task automatic idle_cycles(input int n);
    for (int i = 0; i < n; i++) cyc(0, 3'b000, 4'd0, 0, 0, 0, 0, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    tests++; fails++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    // reset state
    @(negedge clk);
    check(data_vld, 1'b0, "R4", "reset data_vld");
    check(perr, 1'b0, "R2", "reset proto_err");
    check(cal_gnt, 1'b0, "R10", "reset cal_gnt");
    #3 rst_n = 1'b1;
    idle_cycles(2);

    // R2 reserved codes, R3 bad lengths, R1 non-data codes
    cyc(1, 3'b001, 4'd4, 0, 0, 0, 0, 0);
    cyc(1, 3'b011, 4'd4, 0, 0, 0, 0, 0);
    cyc(1, 3'b100, 4'd0, 0, 0, 0, 0, 0);
    cyc(1, 3'b000, 4'd9, 0, 0, 0, 0, 0);
    cyc(1, 3'b110, 4'd2, 0, 0, 0, 0, 0);
    cyc(1, 3'b111, 4'd2, 0, 0, 0, 0, 0);
    idle_cycles(1);

    // R7 iso write length 8 on time, then strobes and throttles go against it
    cyc(1, 3'b101, 4'd8, 1, 1, 1, 1, 1);   // R10: cal denied, iso pending
    cyc(0, 3'b000, 4'd0, 0, 1, 0, 0, 1);
    for (int i = 0; i < 7; i++) cyc(1, 3'b001, 4'd0, 1, 1, 1, 1, 1);  // R11 ignored status
    idle_cycles(1);

    // R5 iso read late by one clock
    cyc(1, 3'b100, 4'd3, 0, 0, 0, 0, 0);
    cyc(0, 3'b000, 4'd0, 0, 1, 0, 0, 0);
    cyc(0, 3'b000, 4'd0, 0, 0, 0, 0, 0);
    idle_cycles(3);

    // R6 iso write late two clocks -> abort
    cyc(1, 3'b101, 4'd5, 0, 0, 0, 0, 0);
    cyc(0, 3'b000, 4'd0, 1, 0, 0, 0, 0);
    cyc(0, 3'b000, 4'd0, 1, 0, 0, 0, 0);
    idle_cycles(2);

    // R8/R9 async write length 8, throttled at index 0 and index 4
    cyc(1, 3'b010, 4'd8, 0, 0, 0, 0, 1);   // R10: cal granted alongside async
    cyc(0, 3'b000, 4'd0, 0, 0, 0, 1, 0);
    cyc(0, 3'b000, 4'd0, 0, 0, 0, 0, 0);
    cyc(0, 3'b000, 4'd0, 1, 1, 1, 1, 0);
    cyc(0, 3'b000, 4'd0, 1, 1, 1, 1, 0);
    cyc(0, 3'b000, 4'd0, 1, 1, 1, 1, 0);
    cyc(0, 3'b000, 4'd0, 0, 0, 0, 1, 0);
    cyc(0, 3'b000, 4'd0, 0, 1, 0, 0, 0);
    cyc(0, 3'b000, 4'd0, 0, 0, 0, 0, 0);
    idle_cycles(4);

    // R4 length 1 iso read
    cyc(1, 3'b100, 4'd1, 0, 0, 0, 0, 0);
    cyc(0, 3'b000, 4'd0, 0, 0, 0, 0, 0);
    idle_cycles(1);

    // random phase
    for (int i = 0; i < 6000; i++) begin
      logic [2:0] c = 3'($urandom_range(0, 7));
      logic [3:0] l = 4'($urandom_range(0, 9));
      cyc(($urandom_range(0, 2) == 0), c, l,
          ($urandom_range(0, 3) == 0), ($urandom_range(0, 3) == 0),
          ($urandom_range(0, 2) == 0), ($urandom_range(0, 2) == 0),
          ($urandom_range(0, 3) == 0));
    end

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule